// File: doc/BRIEF.md
# Debug Scan-Chain Register Access

This block is the data-register side of a debug scan chain. An external debugger shifts a 38-bit frame through it and thereby reads and writes a bank of 32-bit debug registers, each one picked by a 5-bit address. The TAP controller is not part of the block. It is seen only through its capture, shift and update strobes, which are sampled on the rising edge of `tck`. The chain listens to these strobes only while the scan-chain-select input holds the chain number (2 by default) and the internal-test instruction is flagged as loaded.

A read is pipelined across two scans. Update at the end of one scan latches the address. Capture at the start of the next scan loads that register's contents into the data field, which then shifts out on `tdo`.

Every update also produces a request toward the register file: address, write data and a write-enable flag. This request is carried across into the functional clock domain as a single-cycle strobe. A small built-in test bank sits on that port and supplies the read data. Addresses that no bank register answers read as zero, and writes to them do nothing.

Top module: `dbg_scan_access`

## Requirements
- R1: The frame is 38 bits: data in bits 31:0, register address in bits 36:32, access flag in bit 37. It shifts LSB first, so `tdi` supplies bit 0 first and `tdo` presents bit 0 of the captured frame first.
- R2: An update with flag 1 gives exactly one `rf_stb` pulse with `rf_we`=1, and `rf_addr`/`rf_wdata` equal to the frame's address and data fields. The addressed bank register (addresses 0..NUM_REGS-1, default 8 registers) takes the data.
- R3: An update with flag 0 gives one `rf_stb` pulse with `rf_we`=0 and the frame's address, and leaves every bank register unchanged.
- R4: Capture loads bits 31:0 with the contents of the register whose address was latched at the previous update, and loads bits 37:32 with zeros.
- R5: The path is active only when `chain_sel`==2 and `intest_en`=1. Otherwise the capture, shift and update strobes are ignored: the latched address is unchanged, no `rf_stb` is produced, and `tdo` stays 0.
- R6: An address at or above NUM_REGS (for example 20 or 31) captures all zeros. A write to such an address changes no bank register; in particular, address 20 does not alias register 4.
- R7: Reset clears the latched address to 0 and the flag to read, keeps `rf_stb` low, and loads bank register i with 0xA5C30000 + i. The first scan after reset therefore captures 0xA5C30000.
- R8: Each `rf_stb` pulse lasts exactly one `clk` cycle, and no pulse occurs without an update.
- R9: A value written by one scan is returned by the capture of the very next scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Functional-domain reset, active low |
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test-domain reset, active low |
| chain_sel | input | 4 | Current scan-chain-select value |
| intest_en | input | 1 | Internal-test instruction loaded |
| capture_dr | input | 1 | TAP capture strobe |
| shift_dr | input | 1 | TAP shift strobe |
| update_dr | input | 1 | TAP update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of shift register, 0 when inactive) |
| rf_stb | output | 1 | One-cycle register-file request strobe (clk domain) |
| rf_we | output | 1 | Request is a write |
| rf_addr | output | 5 | Request register address |
| rf_wdata | output | 32 | Request write data |

## Verification
A wrong latched address or flag shows up one scan later, as the wrong word on `tdo` during the next capture, or as a wrong `rf_addr`/`rf_we` a few `clk` cycles after the update. A broken toggle or synchronizer shows up within a handful of `clk` cycles after an update, as a missing, doubled or stray `rf_stb`. A bank write that lands on the wrong register or leaks through an unmapped address stays hidden until a later scan reads that register, so the bench reads back both the targeted address and its possible aliases. A gating fault on the chain-select qualifier shows up directly: an inactive scan produces `tdo` activity, an unexpected strobe, or a changed captured word on the following scan.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int FRAME_W = DATA_W + ADDR_W + 1;
    localparam int RW_BIT  = FRAME_W - 1;

    typedef logic [FRAME_W-1:0] frame_t;

    // test-clock side state
    typedef struct packed {
        frame_t              sr;
        logic [ADDR_W-1:0]   addr;
        logic                rw;
        logic [DATA_W-1:0]   wdata;
        logic                tgl;
    } tap_state_t;

    // request as presented on the functional side
    typedef struct packed {
        logic                stb;
        logic                we;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
    } rf_req_t;
endpackage

// File: rtl/dbg_scan_shifter.sv
module dbg_scan_shifter
    import dbg_scan_pkg::*;
#(
    parameter int CHAIN_W  = 4,
    parameter int CHAIN_ID = 2
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic [CHAIN_W-1:0] chain_sel,
    input  logic              intest_en,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    input  logic [DATA_W-1:0] rd_data,
    output logic              tdo,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              lat_rw,
    output logic [DATA_W-1:0] lat_wdata,
    output logic              req_tgl
);
    localparam logic [CHAIN_W-1:0] CHAIN_VAL = CHAIN_W'(CHAIN_ID);
    localparam int                 PAD_W     = FRAME_W - DATA_W;

    tap_state_t st_d, st_q;
    logic       path_on;

    assign path_on = (chain_sel == CHAIN_VAL) && intest_en;

    always_comb begin
        st_d = st_q;
        if (path_on) begin
            if (capture_dr) begin
                st_d.sr = {{PAD_W{1'b0}}, rd_data};
            end else if (shift_dr) begin
                st_d.sr = {tdi, st_q.sr[FRAME_W-1:1]};
            end else if (update_dr) begin
                st_d.addr  = st_q.sr[RW_BIT-1:DATA_W];
                st_d.rw    = st_q.sr[RW_BIT];
                st_d.wdata = st_q.sr[DATA_W-1:0];
                st_d.tgl   = ~st_q.tgl;
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tdo       = path_on & st_q.sr[0];
    assign lat_addr  = st_q.addr;
    assign lat_rw    = st_q.rw;
    assign lat_wdata = st_q.wdata;
    assign req_tgl   = st_q.tgl;
endmodule

// File: rtl/dbg_scan_xing.sv
module dbg_scan_xing
    import dbg_scan_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_tgl,
    input  logic [ADDR_W-1:0] lat_addr,
    input  logic              lat_rw,
    input  logic [DATA_W-1:0] lat_wdata,
    output logic              rf_stb,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata
);
    typedef struct packed {
        logic [SYNC_STAGES:0] sync;
        rf_req_t              req;
    } xing_state_t;

    xing_state_t xs_d, xs_q;
    logic        edge_seen;

    // the last stage is only kept for edge detection
    assign edge_seen = xs_q.sync[SYNC_STAGES] ^ xs_q.sync[SYNC_STAGES-1];

    always_comb begin
        xs_d         = xs_q;
        xs_d.sync    = {xs_q.sync[SYNC_STAGES-1:0], req_tgl};
        xs_d.req.stb = edge_seen;
        if (edge_seen) begin
            xs_d.req.we    = lat_rw;
            xs_d.req.addr  = lat_addr;
            xs_d.req.wdata = lat_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xs_q <= '0;
        else        xs_q <= xs_d;
    end

    assign rf_stb   = xs_q.req.stb;
    assign rf_we    = xs_q.req.we;
    assign rf_addr  = xs_q.req.addr;
    assign rf_wdata = xs_q.req.wdata;
endmodule

// File: rtl/dbg_scan_bank.sv
module dbg_scan_bank
    import dbg_scan_pkg::*;
#(
    parameter int          NUM_REGS = 8,
    parameter logic [31:0] RST_BASE = 32'hA5C3_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_d, regs_q;
    logic                            wr_hit, rd_hit;

    assign wr_hit = wr_stb && wr_en && (int'(wr_addr) < NUM_REGS);
    assign rd_hit = int'(rd_addr) < NUM_REGS;

    always_comb begin
        regs_d = regs_q;
        if (wr_hit) regs_d[wr_addr[IDX_W-1:0]] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= RST_BASE + DATA_W'(i);
        end else begin
            regs_q <= regs_d;
        end
    end

    // read side is quasi-static: the address moves only at update
    assign rd_data = rd_hit ? regs_q[rd_addr[IDX_W-1:0]] : '0;
endmodule

// File: rtl/dbg_scan_access.sv
module dbg_scan_access
    import dbg_scan_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int CHAIN_W     = 4,
    parameter int CHAIN_ID    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tck,
    input  logic               trst_n,
    input  logic [CHAIN_W-1:0] chain_sel,
    input  logic               intest_en,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               tdi,
    output logic               tdo,
    output logic               rf_stb,
    output logic               rf_we,
    output logic [ADDR_W-1:0]  rf_addr,
    output logic [DATA_W-1:0]  rf_wdata
);
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_rw;
    logic [DATA_W-1:0] lat_wdata;
    logic              req_tgl;
    logic [DATA_W-1:0] bank_rdata;

    dbg_scan_shifter #(.CHAIN_W(CHAIN_W), .CHAIN_ID(CHAIN_ID)) u_shift (
        .tck(tck), .trst_n(trst_n), .chain_sel(chain_sel), .intest_en(intest_en),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .rd_data(bank_rdata), .tdo(tdo),
        .lat_addr(lat_addr), .lat_rw(lat_rw), .lat_wdata(lat_wdata), .req_tgl(req_tgl)
    );

    dbg_scan_xing #(.SYNC_STAGES(SYNC_STAGES)) u_xing (
        .clk(clk), .rst_n(rst_n), .req_tgl(req_tgl),
        .lat_addr(lat_addr), .lat_rw(lat_rw), .lat_wdata(lat_wdata),
        .rf_stb(rf_stb), .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata)
    );

    dbg_scan_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_stb(rf_stb), .wr_en(rf_we),
        .wr_addr(rf_addr), .wr_data(rf_wdata),
        .rd_addr(lat_addr), .rd_data(bank_rdata)
    );
endmodule

// File: rtl/dbg_scan_chk.sv
module dbg_scan_chk #(
    parameter int CHAIN_W  = 4,
    parameter int CHAIN_ID = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tck,
    input logic               trst_n,
    input logic [CHAIN_W-1:0] chain_sel,
    input logic               intest_en,
    input logic               update_dr,
    input logic               rf_stb,
    input logic [4:0]         rf_addr,
    input logic [4:0]         lat_addr
);
    // R8
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_stb |=> !rf_stb);

    // R5
    idle_addr_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        ((chain_sel != CHAIN_W'(CHAIN_ID) || !intest_en) && update_dr) |=> $stable(lat_addr));

    // R2
    stb_addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_stb |-> (rf_addr == lat_addr));
endmodule

module dbg_scan_bank_chk #(
    parameter int NUM_REGS = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_stb,
    input logic                      wr_en,
    input logic [4:0]                wr_addr,
    input logic [31:0]               wr_data,
    input logic [NUM_REGS-1:0][31:0] regs
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_en && (int'(wr_addr) < NUM_REGS))
        |=> (regs[$past(wr_addr[IDX_W-1:0])] == $past(wr_data)));

    // R3
    read_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_en) |=> $stable(regs));

    // R6
    unmapped_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (int'(wr_addr) >= NUM_REGS)) |=> $stable(regs));
endmodule

bind dbg_scan_access dbg_scan_chk #(.CHAIN_W(CHAIN_W), .CHAIN_ID(CHAIN_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .tck(tck), .trst_n(trst_n),
    .chain_sel(chain_sel), .intest_en(intest_en), .update_dr(update_dr),
    .rf_stb(rf_stb), .rf_addr(rf_addr), .lat_addr(lat_addr)
);

bind dbg_scan_bank dbg_scan_bank_chk #(.NUM_REGS(NUM_REGS)) u_bchk (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .regs(regs_q)
);

// File: tb/dbg_scan_access_tb_top.sv
module dbg_scan_access_tb_top;
    localparam int NREG = 8;

    logic        clk = 1'b0;
    logic        tck = 1'b0;
    logic        rst_n = 1'b0;
    logic        trst_n = 1'b0;
    logic [3:0]  chain_sel = 4'd0;
    logic        intest_en = 1'b0;
    logic        capture_dr = 1'b0;
    logic        shift_dr = 1'b0;
    logic        update_dr = 1'b0;
    logic        tdi = 1'b0;
    logic        tdo;
    logic        rf_stb;
    logic        rf_we;
    logic [4:0]  rf_addr;
    logic [31:0] rf_wdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [37:0] exp_q[$];
    logic [31:0] model[NREG];
    logic [4:0]  lat_exp;
    logic        prev_stb = 1'b0;

    always #4  clk = ~clk;
    always #50 tck = ~tck;

    dbg_scan_access dut_i (
        .clk(clk), .rst_n(rst_n), .tck(tck), .trst_n(trst_n),
        .chain_sel(chain_sel), .intest_en(intest_en),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .rf_stb(rf_stb), .rf_we(rf_we),
        .rf_addr(rf_addr), .rf_wdata(rf_wdata)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [4:0] a);
        return (int'(a) < NREG) ? model[a[2:0]] : 32'h0;
    endfunction

    // monitor: pops expected requests as strobes appear (R2, R3, R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (rf_stb && prev_stb) check(1'b0, "R8 strobe longer than one cycle", 64'd1, 64'd0);
            if (rf_stb && !prev_stb) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R8 unexpected strobe", {26'd0, rf_we, rf_addr, rf_wdata}, 64'd0);
                end else begin
                    logic [37:0] e;
                    e = exp_q.pop_front();
                    check({rf_we, rf_addr, rf_wdata} == e, "R2/R3 request fields",
                          {26'd0, rf_we, rf_addr, rf_wdata}, {26'd0, e});
                end
            end
            prev_stb <= rf_stb;
        end
    end

    // one full scan: capture, 38 shifts, update
    task automatic scan(input logic rw, input logic [4:0] a, input logic [31:0] d, input string req);
        logic [37:0] fr;
        logic [37:0] got;
        logic [37:0] exp;
        bit          on;
        fr  = {rw, a, d};
        on  = (chain_sel == 4'd2) && intest_en;
        exp = on ? {6'b0, model_rd(lat_exp)} : 38'h0;
        @(negedge tck) capture_dr = 1'b1;
        @(negedge tck) capture_dr = 1'b0;
        for (int i = 0; i < 38; i++) begin
            shift_dr = 1'b1;
            tdi      = fr[i];
            got[i]   = tdo;
            @(negedge tck);
        end
        shift_dr = 1'b0;
        check(got == exp, req, {26'd0, got}, {26'd0, exp});
        if (on) begin
            exp_q.push_back(fr);
            if (rw && int'(a) < NREG) model[a[2:0]] = d;
            lat_exp = a;
        end
        update_dr = 1'b1;
        @(negedge tck) update_dr = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = 32'hA5C3_0000 + 32'(i);
        lat_exp = 5'd0;
        repeat (5) @(negedge clk);
        // R7: outputs quiet in reset
        check(rf_stb == 1'b0, "R7 strobe low in reset", {63'd0, rf_stb}, 64'd0);
        check(tdo == 1'b0, "R7 tdo low in reset", {63'd0, tdo}, 64'd0);
        rst_n = 1'b1;
        @(negedge tck) trst_n = 1'b1;
        chain_sel = 4'd2;
        intest_en = 1'b1;

        // R7 / R1 / R4: first capture returns register 0 reset value
        scan(1'b0, 5'd3, 32'h0, "R7 first capture after reset");
        scan(1'b0, 5'd7, 32'h1357_9BDF, "R3 R4 read reg3");
        // R2 / R9: write then read back on next scan
        scan(1'b1, 5'd5, 32'h1234_5678, "R4 read reg7");
        scan(1'b1, 5'd0, 32'hAAAA_AAAA, "R9 readback reg5");
        scan(1'b1, 5'd7, 32'hFFFF_FFFF, "R9 readback reg0");
        scan(1'b0, 5'd5, 32'h0, "R9 readback reg7 all ones");
        scan(1'b0, 5'd20, 32'h0, "R1 R3 reg5 still written value");
        // R6: unmapped reads zero, writes do not alias
        scan(1'b1, 5'd20, 32'hDEAD_BEEF, "R6 unmapped read zero");
        scan(1'b0, 5'd4, 32'h0, "R6 unmapped after write still zero");
        scan(1'b0, 5'd31, 32'h0, "R6 reg4 not aliased");
        scan(1'b0, 5'd1, 32'h0, "R6 addr31 zero");

        // R5: wrong chain number
        chain_sel = 4'd3;
        scan(1'b1, 5'd1, 32'h0BAD_0001, "R5 inactive chain tdo quiet");
        chain_sel = 4'd2;
        intest_en = 1'b0;
        scan(1'b1, 5'd6, 32'h0BAD_0002, "R5 no intest tdo quiet");
        intest_en = 1'b1;
        scan(1'b0, 5'd6, 32'h0, "R5 latched address kept reg1");
        scan(1'b0, 5'd2, 32'h0, "R5 reg6 untouched");
        scan(1'b1, 5'd2, 32'h5555_0000, "R4 reg2 reset value");
        scan(1'b0, 5'd2, 32'h0, "R9 back-to-back write reg2");

        repeat (30) @(negedge clk);
        check(exp_q.size() == 0, "R8 every update strobed", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule